// File: doc/BRIEF.md
# Cross-Coupled Dual-Edge Counter

This block is a modulo-200 counter that takes one step on every clock edge, rising and falling alike. It gives a compare or duty-cycle generator twice the count resolution of a single-edge counter while the clock frequency stays the same. There is one count value, not one per edge, so a downstream compare against any value from 0 to 199 sees a single sequence that has no gaps.

The count is held in a pair of registers. One is clocked on the rising edge and one on the falling edge. Each edge computes the next count from the present combined count, which is the step the other register last took. The two registers are kept so that their bitwise XOR is the count. At each edge, the register that updates stores the next count XOR the other register, which does not move on that edge. The clock therefore never enters the data path, and no clock-gated multiplexer feeds the compare. A one-bit register pair of the same kind produces a wrap pulse that is high for the half-period after the count goes from 199 to 0.

The next-step decision falls into one of four named step kinds:
- CLEAR: reset.
- HOLD: enable low.
- ADVANCE: count + 1.
- WRAP: from 199 or above, load 0 and raise the wrap flag.

The same decision logic serves both edges.

Top module: `dual_edge_counter`

## Requirements
- R1: Outside reset, `count` always lies in the range 0 to MOD-1 (0 to 199 by default).
- R2: On every clock edge, rising or falling, where `en` is high and `rst` is low, `count` goes from N to N+1 for N below MOD-1. The new value is visible right after that edge.
- R3: On an enabled edge where `count` is MOD-1 (199), `count` becomes 0.
- R4: On an edge where `en` is low and `rst` is low, `count` keeps its value.
- R5: With `rst` high on a rising edge and on the falling edge that follows, `count` is 0 and `wrap` is 0 from that falling edge on. The first enabled edge after `rst` falls gives a count of 1.
- R6: `wrap` is 1 for exactly the half-period that follows an enabled edge which took `count` from MOD-1 to 0, and it is 0 at all other times outside reset.
- R7: `en` is sampled separately at each edge. With `en` high only at rising edges, the count advances by exactly one per clock cycle and holds across every falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both edges are active |
| rst | input | 1 | Synchronous reset, active high, sampled at both edges |
| en | input | 1 | Count enable, active high, sampled at each edge |
| count | output | $clog2(MOD) (8) | Combined count, plain binary |
| wrap | output | 1 | High for the half-period after a 199-to-0 step |

## Verification
The count is the XOR of two registers, so a wrong value in either register shows up on `count` right after the next edge. It appears as a jump, a repeated value or a value above 199, not as a slow drift. A bench model steps once per edge, and a comparison half a phase later catches such a fault within one half-period. Edges with enable low, the 199 boundary and a reset in mid-run are each compared separately. This places a fault on one edge's register in the step kind where it occurred.

// File: rtl/dec_pkg.sv
package dec_pkg;

    // Kind of step taken by the counter at one clock edge.
    typedef enum logic [1:0] {
        STEP_CLEAR   = 2'd0,
        STEP_HOLD    = 2'd1,
        STEP_ADVANCE = 2'd2,
        STEP_WRAP    = 2'd3
    } step_e;

endpackage

// File: rtl/dec_step_logic.sv
module dec_step_logic
    import dec_pkg::*;
#(
    parameter int MOD = 200,
    localparam int CW = $clog2(MOD)
) (
    input  logic          rst,
    input  logic          en,
    input  logic [CW-1:0] cur,
    output logic [CW-1:0] nxt,
    output logic          wrap_nxt
);

    localparam logic [CW-1:0] CNT_MAX = CW'(MOD - 1);

    step_e kind;

    // Pick the step kind for the coming edge.
    always_comb begin
        if (rst) begin
            kind = STEP_CLEAR;
        end else if (!en) begin
            kind = STEP_HOLD;
        end else if (cur >= CNT_MAX) begin
            kind = STEP_WRAP;
        end else begin
            kind = STEP_ADVANCE;
        end
    end

    // Next count and wrap flag for each step kind.
    always_comb begin
        unique case (kind)
            STEP_CLEAR: begin
                nxt      = '0;
                wrap_nxt = 1'b0;
            end
            STEP_HOLD: begin
                nxt      = cur;
                wrap_nxt = 1'b0;
            end
            STEP_ADVANCE: begin
                nxt      = cur + CW'(1);
                wrap_nxt = 1'b0;
            end
            STEP_WRAP: begin
                nxt      = '0;
                wrap_nxt = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dec_edge_pair.sv
module dec_edge_pair #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] q
);

    logic [W-1:0] rise_q;
    logic [W-1:0] fall_q;

    // Rising-edge half: stores the new value folded with the falling half.
    always_ff @(posedge clk) begin
        if (rst) begin
            rise_q <= '0;
        end else begin
            rise_q <= nxt ^ fall_q;
        end
    end

    // Falling-edge half: stores the new value folded with the rising half.
    always_ff @(negedge clk) begin
        if (rst) begin
            fall_q <= '0;
        end else begin
            fall_q <= nxt ^ rise_q;
        end
    end

    // Only one half moves per edge, so the XOR is the last value written.
    assign q = rise_q ^ fall_q;

endmodule

// File: rtl/dual_edge_counter.sv
module dual_edge_counter #(
    parameter int MOD = 200,
    localparam int CW = $clog2(MOD)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output logic [CW-1:0] count,
    output logic          wrap
);

    localparam logic [CW-1:0] CNT_MAX = CW'(MOD - 1);

    logic [CW-1:0] cnt_nxt;
    logic          wrap_nxt;
    logic [0:0]    wrap_q;

    dec_step_logic #(.MOD(MOD)) u_step (
        .rst      (rst),
        .en       (en),
        .cur      (count),
        .nxt      (cnt_nxt),
        .wrap_nxt (wrap_nxt)
    );

    dec_edge_pair #(.W(CW)) u_cnt (
        .clk (clk),
        .rst (rst),
        .nxt (cnt_nxt),
        .q   (count)
    );

    dec_edge_pair #(.W(1)) u_wrap (
        .clk (clk),
        .rst (rst),
        .nxt (wrap_nxt),
        .q   (wrap_q)
    );

    assign wrap = wrap_q[0];

    // Snapshots of the count and the inputs taken at each edge, for the
    // edge-to-edge checks below.
    logic [CW-1:0] snap_r_cnt, snap_f_cnt;
    logic          snap_r_en, snap_f_en;
    logic          snap_r_rst, snap_f_rst;

    always_ff @(posedge clk) begin
        snap_r_cnt <= count;
        snap_r_en  <= en;
        snap_r_rst <= rst;
    end

    always_ff @(negedge clk) begin
        snap_f_cnt <= count;
        snap_f_en  <= en;
        snap_f_rst <= rst;
    end

    // R2 / R3: step taken at a rising edge, seen at the next falling edge
    a_r2_rise_step: assert property (@(negedge clk) disable iff (rst)
        (!snap_r_rst && snap_r_en) |->
        count == ((snap_r_cnt >= CNT_MAX) ? '0 : snap_r_cnt + CW'(1)));

    // R2 / R3: step taken at a falling edge, seen at the next rising edge
    a_r2_fall_step: assert property (@(posedge clk) disable iff (rst)
        (!snap_f_rst && snap_f_en) |->
        count == ((snap_f_cnt >= CNT_MAX) ? '0 : snap_f_cnt + CW'(1)));

    // R4: enable low at a rising edge holds the count
    a_r4_rise_hold: assert property (@(negedge clk) disable iff (rst)
        (!snap_r_rst && !snap_r_en) |-> count == snap_r_cnt);

    // R4: enable low at a falling edge holds the count
    a_r4_fall_hold: assert property (@(posedge clk) disable iff (rst)
        (!snap_f_rst && !snap_f_en) |-> count == snap_f_cnt);

    // R1: count stays in range
    a_r1_range: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_MAX);

    // R6: wrap follows a MOD-1 to 0 step at a rising edge
    a_r6_wrap_rise: assert property (@(negedge clk) disable iff (rst)
        (!snap_r_rst && snap_r_en && snap_r_cnt == CNT_MAX) |-> wrap);

    // R6: wrap only ever accompanies a count of zero
    a_r6_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        wrap |-> count == '0);

    // R5: reset on a rising edge and the following falling edge clears both outputs
    a_r5_reset_clear: assert property (@(posedge clk)
        (snap_r_rst === 1'b1 && snap_f_rst === 1'b1) |-> (count == '0 && !wrap));

endmodule

// File: tb/tb_dual_edge_counter.sv
module tb_dual_edge_counter;

    localparam int MOD = 200;
    localparam int CW  = $clog2(MOD);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [CW-1:0] count;
    logic          wrap;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    bit phase_r7 = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dual_edge_counter #(.MOD(MOD)) dut (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .count (count),
        .wrap  (wrap)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: one integer count stepped at every edge.
    int    m_cnt = 0;
    int    m_wrap = 0;
    bit    prev_rst = 1'b0;
    bit    live = 1'b0;
    bit    skip;
    bit    rising;
    bit    s_rst;
    bit    s_en;
    string tag;

    initial begin
        forever begin
            @(clk);
            rising = clk;
            s_rst  = rst;
            s_en   = en;
            skip   = 1'b0;
            if (s_rst) begin
                m_cnt  = 0;
                m_wrap = 0;
                tag    = "R5";
                if (rising && !prev_rst) skip = 1'b1;   // only one half cleared yet
                if (!rising && prev_rst) live = 1'b1;
            end else if (!s_en) begin
                m_wrap = 0;
                tag    = phase_r7 ? "R7" : "R4";
            end else if (m_cnt >= MOD - 1) begin
                m_cnt  = 0;
                m_wrap = 1;
                tag    = "R3";
            end else begin
                m_cnt  = m_cnt + 1;
                m_wrap = 0;
                tag    = phase_r7 ? "R7" : "R2";
            end
            prev_rst = s_rst;
            #1;
            if (live && !skip && !done) begin
                chk(tag, int'(count), m_cnt);
                chk("R6", int'(wrap), m_wrap);
                chk("R1", int'(count < CW'(MOD)), 1);
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL R2 watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R5", int'(count), 0);
        chk("R5", int'(wrap), 0);
        #1;
        rst = 1'b0;
        en  = 1'b1;

        // free run across two wraps
        repeat (450) @(clk);

        // enable varied per edge
        for (int i = 0; i < 240; i++) begin
            @(clk);
            #2;
            en = (i % 3) != 0;
        end

        // enable only at rising edges
        @(negedge clk);
        #2;
        phase_r7 = 1'b1;
        for (int i = 0; i < 200; i++) begin
            en = (clk == 1'b0);
            @(clk);
            #2;
        end
        phase_r7 = 1'b0;

        // long hold
        en = 1'b0;
        repeat (40) @(clk);

        // mid-run reset
        @(negedge clk);
        #2;
        en  = 1'b1;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R5", int'(count), 0);
        chk("R5", int'(wrap), 0);
        #1;
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R5", int'(count), 1);

        // run through the boundary again
        repeat (420) @(clk);

        #2;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule